// File: doc/BRIEF.md
# Two-Pin Control I/O with Status-Change Interrupt

This block serves two general-purpose control pins from a small register file. A host writes an output level for each pin and picks, through a mode register, whether the pins drive those levels or float at high impedance and act as inputs. A status word gathers the sampled pin levels and a set of further status bits that come in from the rest of the chip. The host reads all of these through the block's own register port.

An optional interrupt mode turns the second pin into a level-active, active-high request line. The request rises whenever any bit of the status word changes, not only the pin bits, so the host does not have to poll. It stays high until the host reads the status word. Pin inputs pass through a synchronizer before they reach the status word. This keeps a metastable sample from appearing as a change.

Top module: `ctl_pins_irq`

## Requirements
- R1: After reset both pad output-enables are low, interrupt mode is off, the mode register reads 1 (high impedance set), the level register reads 0 and the interrupt is deasserted.
- R2: Register map: address 0 is the level register (bit 0 sets the level of pin 0 and bit 1 sets the level of pin 1). Address 1 is the mode register (bit 0 selects high impedance and bit 1 enables interrupt mode). Address 2 is the read-only status word, and writes to it have no effect.
- R3: With the high-impedance bit clear, both pads are enabled and drive the level register. Status bits [1:0] show the driven levels.
- R4: With the high-impedance bit set, both output-enables are low outside interrupt mode. Status bits [1:0] show the pad inputs through a two-stage synchronizer, and a pad change first appears after the third rising clock edge.
- R5: Status bits [DATA_W-1:2] show the `ext_status` input, registered once.
- R6: A change of any status bit, with bit 1 excluded in interrupt mode, sets the interrupt on the same edge that loads the changed status word.
- R7: Once set, the interrupt stays asserted until a read of address 2 (`rd_en` high at a rising edge), which clears it.
- R8: A status change on the same edge as a clearing read leaves the interrupt asserted.
- R9: In interrupt mode, pin 1's output-enable is high whatever the high-impedance bit says, and it drives the interrupt level. Status bit 1 shows the interrupt level, and `pad_in[1]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe (clears the interrupt when the address is 2) |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Read data, combinational from the address |
| ext_status | input | DATA_W-2 | Further status bits from elsewhere in the chip |
| pad_in | input | 2 | Pad input levels |
| pad_out | output | 2 | Pad output levels |
| pad_oe | output | 2 | Pad output-enables |

## Verification
The hardest case to reach is a status change that lands on exactly the edge that carries a clearing read. To reach it, the bench puts a new `ext_status` value on the same falling edge where it raises the read strobe, while the interrupt is already high. It then checks that pin 1 is still high one edge later. The bench also has to show there is no self-triggering storm in interrupt mode. For this it clears the request and watches pin 1 stay low for several cycles while it toggles `pad_in[1]`, which must now have no effect.

// File: rtl/ctlpin_pkg.sv
package ctlpin_pkg;

    localparam int NUM_PINS = 2;
    localparam int ADDR_W   = 2;

    localparam logic [ADDR_W-1:0] ADDR_LEVEL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MODE   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;

    // Mode register: field order matches its write-data bits.
    typedef struct packed {
        logic irq_en;   // bit 1
        logic hiz;      // bit 0
    } mode_t;

    localparam mode_t MODE_RESET = '{irq_en: 1'b0, hiz: 1'b1};

    // Bits that take part in change detection.
    function automatic logic [NUM_PINS-1:0] pin_change_mask(input mode_t m);
        return {~m.irq_en, 1'b1};
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
    import ctlpin_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [DATA_W-1:0]   status_i,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_PINS-1:0] level_q,
    output mode_t               mode_q,
    output logic                stat_rd
);
    localparam int PAD_W = DATA_W - NUM_PINS;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            mode_q  <= MODE_RESET;
        end else if (wr_en) begin
            if (wr_addr == ADDR_LEVEL) level_q <= wr_data[NUM_PINS-1:0];
            if (wr_addr == ADDR_MODE)  mode_q  <= mode_t'(wr_data[1:0]);
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_LEVEL:  rd_data = {{PAD_W{1'b0}}, level_q};
            ADDR_MODE:   rd_data = {{PAD_W{1'b0}}, mode_q};
            ADDR_STATUS: rd_data = status_i;
            default:     rd_data = '0;
        endcase
    end

    assign stat_rd = rd_en && (rd_addr == ADDR_STATUS);
endmodule

// File: rtl/status_irq.sv
module status_irq
    import ctlpin_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PINS-1:0]        pins_sync,
    input  logic [NUM_PINS-1:0]        level_q,
    input  mode_t                      mode_q,
    input  logic [DATA_W-NUM_PINS-1:0] ext_status,
    input  logic                       clr,
    output logic [DATA_W-1:0]          status_q,
    output logic                       irq_q,
    output logic                       chg
);
    localparam int EXT_W = DATA_W - NUM_PINS;

    logic [NUM_PINS-1:0] pin_bits;
    logic [DATA_W-1:0]   status_d;
    logic [DATA_W-1:0]   diff_mask;

    always_comb begin
        pin_bits[0] = mode_q.hiz ? pins_sync[0] : level_q[0];
        if (mode_q.irq_en) pin_bits[1] = irq_q;
        else               pin_bits[1] = mode_q.hiz ? pins_sync[1] : level_q[1];
    end

    assign status_d  = {ext_status, pin_bits};
    assign diff_mask = {{EXT_W{1'b1}}, pin_change_mask(mode_q)};
    assign chg       = |((status_d ^ status_q) & diff_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            irq_q    <= chg | (irq_q & ~clr);
        end
    end
endmodule

// File: rtl/ctl_pins_irq.sv
module ctl_pins_irq
    import ctlpin_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_en,
    input  logic [1:0]                 rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    input  logic [DATA_W-3:0]          ext_status,
    input  logic [1:0]                 pad_in,
    output logic [1:0]                 pad_out,
    output logic [1:0]                 pad_oe
);
    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] level_q;
    mode_t               mode_q;
    logic                stat_rd;
    logic [DATA_W-1:0]   status_q;
    logic                irq_q;
    logic                chg;

    pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(sync_q)
    );

    ctl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .status_i(status_q), .rd_data(rd_data),
        .level_q(level_q), .mode_q(mode_q), .stat_rd(stat_rd)
    );

    status_irq #(.DATA_W(DATA_W)) u_stat (
        .clk(clk), .rst(rst),
        .pins_sync(sync_q), .level_q(level_q), .mode_q(mode_q),
        .ext_status(ext_status), .clr(stat_rd),
        .status_q(status_q), .irq_q(irq_q), .chg(chg)
    );

    assign pad_out[0] = level_q[0];
    assign pad_oe[0]  = ~mode_q.hiz;
    assign pad_out[1] = mode_q.irq_en ? irq_q : level_q[1];
    assign pad_oe[1]  = mode_q.irq_en | ~mode_q.hiz;
endmodule

// File: rtl/ctl_pins_irq_chk.sv
module ctl_pins_irq_chk
    import ctlpin_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        pad_out,
    input logic [1:0]        pad_oe,
    input mode_t             mode_q,
    input logic [1:0]        sync_q,
    input logic [DATA_W-1:0] status_q,
    input logic              irq_q,
    input logic              chg,
    input logic              stat_rd
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (pad_oe == 2'b00 && !irq_q && mode_q.hiz && !mode_q.irq_en));

    assert_hiz_sample_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q.hiz && !mode_q.irq_en) |=> (status_q[1:0] == $past(sync_q)));

    assert_irq_set_R6: assert property (@(posedge clk) disable iff (rst)
        chg |=> irq_q);

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !stat_rd) |=> irq_q);

    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !chg) |=> !irq_q);

    assert_pin1_irq_R9: assert property (@(posedge clk) disable iff (rst)
        mode_q.irq_en |-> (pad_oe[1] && pad_out[1] == irq_q));
endmodule

bind ctl_pins_irq ctl_pins_irq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .pad_out(pad_out), .pad_oe(pad_oe),
    .mode_q(mode_q), .sync_q(sync_q), .status_q(status_q),
    .irq_q(irq_q), .chg(chg), .stat_rd(stat_rd)
);

// File: tb/test_ctl_pins_irq.sv
`timescale 1ns/1ps
module test_ctl_pins_irq;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [1:0]        wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              rd_en;
    logic [1:0]        rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-3:0] ext_status;
    logic [1:0]        pad_in;
    logic [1:0]        pad_out;
    logic [1:0]        pad_oe;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ctl_pins_irq #(.DATA_W(DATA_W)) i_ctl_pins_irq (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_status(ext_status), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Reads at a falling edge; the strobe is seen by the next rising edge.
    task automatic reg_rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [DATA_W-1:0] d;
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        reg_rd(2'd1, d);
        check("R1 mode reg", 32'(d), 32'h1);
        reg_rd(2'd0, d);
        check("R1 level reg", 32'(d), 32'h0);
        reg_rd(2'd2, d);
        check("R1 status", 32'(d), 32'h0);
    endtask

    task automatic t_drive;
        logic [DATA_W-1:0] d;
        reg_wr(2'd0, 8'h02);
        reg_wr(2'd1, 8'h00);
        check("R3 pad_oe", 32'(pad_oe), 32'h3);
        check("R3 pad_out", 32'(pad_out), 32'h2);
        edges(1);
        reg_rd(2'd2, d);
        check("R3 status pins", 32'(d[1:0]), 32'h2);
        reg_wr(2'd2, 8'hFF);
        reg_rd(2'd0, d);
        check("R2 status write ignored (level)", 32'(d), 32'h2);
        reg_rd(2'd1, d);
        check("R2 status write ignored (mode)", 32'(d), 32'h0);
        reg_rd(2'd2, d);
        check("R2 status write ignored (status)", 32'(d), 32'h2);
    endtask

    task automatic t_input;
        logic [DATA_W-1:0] d;
        reg_wr(2'd1, 8'h01);
        check("R4 pad_oe released", 32'(pad_oe), 32'h0);
        edges(3);
        @(negedge clk);
        pad_in = 2'b01;
        edges(2);
        #1 d = rd_data;
        rd_addr = 2'd2;
        #1 check("R4 not yet after two edges", 32'(rd_data[1:0]), 32'h0);
        edges(1);
        #1 check("R4 visible after third edge", 32'(rd_data[1:0]), 32'h1);
        @(negedge clk);
        ext_status = 6'h2A;
        edges(1);
        #1 check("R5 ext_status in status", 32'(rd_data), 32'hA9);
    endtask

    task automatic t_irq_basic;
        logic [DATA_W-1:0] d;
        reg_wr(2'd1, 8'h02);
        check("R9 pad_oe with irq", 32'(pad_oe), 32'h3);
        edges(3);
        reg_rd(2'd2, d);
        edges(1);
        check("R7 cleared by read", 32'(pad_out[1]), 32'h0);
        @(negedge clk);
        ext_status = 6'h15;
        edges(1);
        check("R6 set on ext change", 32'(pad_out[1]), 32'h1);
        edges(5);
        check("R7 held until read", 32'(pad_out[1]), 32'h1);
        reg_rd(2'd0, d);
        check("R7 non-status read keeps irq", 32'(pad_out[1]), 32'h1);
        reg_rd(2'd2, d);
        check("R7 cleared after status read", 32'(pad_out[1]), 32'h0);
    endtask

    task automatic t_irq_pin;
        logic [DATA_W-1:0] d;
        reg_wr(2'd1, 8'h03);
        check("R9 oe forced in hiz", 32'(pad_oe), 32'h2);
        edges(3);
        reg_rd(2'd2, d);
        edges(1);
        @(negedge clk);
        pad_in = 2'b00;
        edges(2);
        check("R6 pin change not yet", 32'(pad_out[1]), 32'h0);
        edges(1);
        check("R6 pin change sets irq", 32'(pad_out[1]), 32'h1);
        edges(2);
        reg_rd(2'd2, d);
        check("R9 status bit1 shows irq", 32'(d[1]), 32'h1);
        edges(1);
        check("R7 clear in irq mode", 32'(pad_out[1]), 32'h0);
        @(negedge clk);
        pad_in = 2'b10;
        edges(5);
        check("R9 pad_in[1] ignored, no retrigger", 32'(pad_out[1]), 32'h0);
        reg_rd(2'd2, d);
        check("R9 status bit1 reads low irq", 32'(d[1:0]), 32'h0);
    endtask

    task automatic t_collide;
        logic [DATA_W-1:0] d;
        @(negedge clk);
        ext_status = 6'h07;
        edges(1);
        check("R6 set before collide", 32'(pad_out[1]), 32'h1);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 2'd2; ext_status = 6'h08;
        @(negedge clk);
        rd_en = 1'b0;
        check("R8 change with clearing read", 32'(pad_out[1]), 32'h1);
        reg_rd(2'd2, d);
        check("R8 next read clears", 32'(pad_out[1]), 32'h0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_en = 1'b0; rd_addr = '0; ext_status = '0; pad_in = '0;
        edges(4);
        rst = 1'b0;
        t_reset();
        t_drive();
        t_input();
        t_irq_basic();
        t_irq_pin();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule